// File: doc/BRIEF.md
# Packed BCD Byte Arithmetic Unit

This unit performs decimal arithmetic on one byte holding two packed BCD digits. It offers three operations: addition with an incoming extend bit, subtraction with an incoming extend bit, and negation with an incoming extend bit. The extend bit acts as the decimal carry or borrow, so a chain of bytes can be processed one byte after another. The unit produces the corrected byte and five condition flags: extend, negative, zero, overflow and carry.

A request is accepted on any clock edge where `start_i` is high. The operands, the operation code, the incoming extend bit and the incoming zero flag are sampled on that edge. The result and the flags are registered and appear after that edge, together with a single-cycle `done_o` pulse. They then hold until the next request.

Digits outside 0 to 9 get no special handling. They pass through the same fixed binary correction steps as valid digits. As a result, the output for such inputs is fully determined.

Top module: `bcd_byte_alu`

## Requirements
- R1: With op 0 (add), lo = src[3:0] + dst[3:0] + x and raw = (src & 0xF0) + (dst & 0xF0) + lo, computed 10 bits wide. If lo > 9, 6 is added to raw. The result is the low byte after the carry correction of R2.
- R2: In an add, C is set when bits 9:4 of the value after the low-digit step exceed 0x90. When C is set, 0x60 is added before the byte is taken. V is set when raw bit 7 is 0 and the final byte bit 7 is 1.
- R3: With op 1 (subtract), lo = dst[3:0] − src[3:0] − x and raw = (dst & 0xF0) − (src & 0xF0) + lo, modulo 2^10. If any of lo bits 7:4 is set, 6 is subtracted. Then 0x60 is subtracted when dst − src − x borrows, that is, when bit 8 is set.
- R4: In a subtract, C is set when dst − src − k − x, taken modulo 2^10, has bit 8 or bit 9 set. Here k is 6 if the low-digit step of R3 fired and 0 otherwise. V is set when raw bit 7 is 1 and the final byte bit 7 is 0.
- R5: With op 2 (negate), lo = 0 − src[3:0] − x as an unsigned value. If lo > 9, 6 is subtracted from it. The value is then (0 − (src & 0xF0)) + lo. C is set when bits 8:4 of the value exceed 0x90, and 0x60 is then subtracted. V keeps its previous registered value.
- R6: The X output always equals the new C. N equals bit 7 of the result byte.
- R7: Z is cleared when the result byte is nonzero. Otherwise Z takes the value of `z_i`.
- R8: Result and flags update only on an edge with `start_i` high and are visible after that edge. `done_o` is high for exactly the cycle after each start edge. Without a start, all outputs hold and `done_o` is low.
- R9: After a synchronous reset (`rst_n` low at an edge), the result, all flags and `done_o` are 0.
- R10: Op code 3 is reserved and behaves exactly as add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe |
| op_i | input | 2 | 0 add, 1 subtract, 2 negate, 3 add |
| src_i | input | 8 | Source byte |
| dst_i | input | 8 | Destination byte (unused by negate) |
| x_i | input | 1 | Incoming extend bit |
| z_i | input | 1 | Incoming zero flag |
| result_o | output | 8 | Corrected result byte |
| flag_x_o | output | 1 | Extend flag |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry/borrow flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `start_i`, `op_i` and the operands are settled before each clock edge. They also assume that reset is held for at least one edge before the first request. The stimulus drives every input on the falling edge, a half period away from the sampling edge. It asserts reset for several edges before any request, so both conditions always hold. The operand values need no such assumption, because non-decimal digits are defined behaviour. Random bytes are therefore drawn over the full range rather than restricted to valid digits.

// File: rtl/bcd_alu_pkg.sv
// Shared widths, constants and operation codes for the packed BCD byte unit.
// Assumes one byte holds two 4-bit digits; intermediates are kept WIDE_W bits.
package bcd_alu_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int WIDE_W = BYTE_W + 2;
    localparam int OP_W   = 2;

    localparam logic [WIDE_W-1:0] LO_FIX   = WIDE_W'(6);
    localparam logic [WIDE_W-1:0] HI_FIX   = WIDE_W'(6) << NIB_W;
    localparam logic [WIDE_W-1:0] HI_LIMIT = WIDE_W'(9) << NIB_W;
    localparam logic [WIDE_W-1:0] LO_LIMIT = WIDE_W'(9);

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_NEG  = 2'd2,
        OP_RSVD = 2'd3
    } bcd_op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] res;
        logic              c;
        logic              v;
    } bcd_out_t;
endpackage

// File: rtl/bcd_add_unit.sv
// Decimal add with extend: low digit corrected first, then the high digit.
// Assumes nothing about digit validity; binary correction rules apply always.
module bcd_add_unit
    import bcd_alu_pkg::*;
(
    input  logic [BYTE_W-1:0] src,
    input  logic [BYTE_W-1:0] dst,
    input  logic              x,
    output bcd_out_t          out
);
    localparam logic [WIDE_W-1:0] HI_MASK = {{(WIDE_W-NIB_W){1'b1}}, {NIB_W{1'b0}}};

    logic [WIDE_W-1:0] lo_sum, hi_sum, raw, step1, fin;
    logic              carry;

    // Partial sums, correction chain and flag derivation.
    always_comb begin
        lo_sum = WIDE_W'(src[NIB_W-1:0]) + WIDE_W'(dst[NIB_W-1:0]) + WIDE_W'(x);
        hi_sum = WIDE_W'({src[BYTE_W-1:NIB_W], {NIB_W{1'b0}}})
               + WIDE_W'({dst[BYTE_W-1:NIB_W], {NIB_W{1'b0}}});
        raw    = hi_sum + lo_sum;
        step1  = (lo_sum > LO_LIMIT) ? raw + LO_FIX : raw;
        carry  = (step1 & HI_MASK) > HI_LIMIT;
        fin    = carry ? step1 + HI_FIX : step1;
        out.res = fin[BYTE_W-1:0];
        out.c   = carry;
        out.v   = !raw[BYTE_W-1] && fin[BYTE_W-1];
    end
endmodule

// File: rtl/bcd_sub_unit.sv
// Decimal subtract with extend (dst - src - x) using borrow-driven corrections.
// Assumes modulo-2^WIDE_W arithmetic matches the required borrow bits.
module bcd_sub_unit
    import bcd_alu_pkg::*;
(
    input  logic [BYTE_W-1:0] src,
    input  logic [BYTE_W-1:0] dst,
    input  logic              x,
    output bcd_out_t          out
);
    logic [WIDE_W-1:0] lo_dif, hi_dif, raw, step1, fin, bin_dif, c_dif;
    logic              lo_fire, borrow;

    // Partial differences, ordered corrections and flag derivation.
    always_comb begin
        lo_dif  = WIDE_W'(dst[NIB_W-1:0]) - WIDE_W'(src[NIB_W-1:0]) - WIDE_W'(x);
        hi_dif  = WIDE_W'({dst[BYTE_W-1:NIB_W], {NIB_W{1'b0}}})
                - WIDE_W'({src[BYTE_W-1:NIB_W], {NIB_W{1'b0}}});
        raw     = hi_dif + lo_dif;
        lo_fire = |lo_dif[BYTE_W-1:NIB_W];
        step1   = lo_fire ? raw - LO_FIX : raw;
        bin_dif = WIDE_W'(dst) - WIDE_W'(src) - WIDE_W'(x);
        borrow  = bin_dif[BYTE_W];
        fin     = borrow ? step1 - HI_FIX : step1;
        c_dif   = bin_dif - (lo_fire ? LO_FIX : '0);
        out.res = fin[BYTE_W-1:0];
        out.c   = |c_dif[WIDE_W-1:BYTE_W];
        out.v   = raw[BYTE_W-1] && !fin[BYTE_W-1];
    end
endmodule

// File: rtl/bcd_neg_unit.sv
// Decimal negate with extend (0 - src - x); produces no overflow of its own.
// Assumes the caller retains the previous overflow flag.
module bcd_neg_unit
    import bcd_alu_pkg::*;
(
    input  logic [BYTE_W-1:0] src,
    input  logic              x,
    output bcd_out_t          out
);
    localparam logic [WIDE_W-1:0] HI_MASK = {{(WIDE_W-BYTE_W-1){1'b0}}, {(BYTE_W+1-NIB_W){1'b1}}, {NIB_W{1'b0}}};

    logic [WIDE_W-1:0] lo_neg, lo_adj, hi_neg, val, fin;
    logic              carry;

    // Low digit fix before combining, then high digit fix.
    always_comb begin
        lo_neg = '0 - WIDE_W'(src[NIB_W-1:0]) - WIDE_W'(x);
        lo_adj = (lo_neg > LO_LIMIT) ? lo_neg - LO_FIX : lo_neg;
        hi_neg = '0 - WIDE_W'({src[BYTE_W-1:NIB_W], {NIB_W{1'b0}}});
        val    = hi_neg + lo_adj;
        carry  = (val & HI_MASK) > HI_LIMIT;
        fin    = carry ? val - HI_FIX : val;
        out.res = fin[BYTE_W-1:0];
        out.c   = carry;
        out.v   = 1'b0;
    end
endmodule

// File: rtl/bcd_byte_alu.sv
// Top of the packed BCD byte unit: selects one of three arithmetic cores,
// derives N/Z/X and registers everything on a start edge with a done pulse.
// Assumes inputs are stable around the rising edge; reset is synchronous.
module bcd_byte_alu
    import bcd_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [BYTE_W-1:0] src_i,
    input  logic [BYTE_W-1:0] dst_i,
    input  logic              x_i,
    input  logic              z_i,
    output logic [BYTE_W-1:0] result_o,
    output logic              flag_x_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_v_o,
    output logic              flag_c_o,
    output logic              done_o
);
    bcd_out_t add_o, sub_o, neg_o, sel_o;
    logic     keep_v;

    bcd_add_unit u_add (.src(src_i), .dst(dst_i), .x(x_i), .out(add_o));
    bcd_sub_unit u_sub (.src(src_i), .dst(dst_i), .x(x_i), .out(sub_o));
    bcd_neg_unit u_neg (.src(src_i), .x(x_i), .out(neg_o));

    // Pick the core output; reserved code falls back to add.
    always_comb begin
        keep_v = 1'b0;
        unique case (bcd_op_e'(op_i))
            OP_SUB:  sel_o = sub_o;
            OP_NEG:  begin sel_o = neg_o; keep_v = 1'b1; end
            default: sel_o = add_o;
        endcase
    end

    // Register result and flags on start; pulse done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            flag_x_o <= 1'b0;
            flag_n_o <= 1'b0;
            flag_z_o <= 1'b0;
            flag_v_o <= 1'b0;
            flag_c_o <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                result_o <= sel_o.res;
                flag_c_o <= sel_o.c;
                flag_x_o <= sel_o.c;
                flag_n_o <= sel_o.res[BYTE_W-1];
                flag_z_o <= z_i && (sel_o.res == '0);
                if (!keep_v) flag_v_o <= sel_o.v;
            end
        end
    end
endmodule

// File: rtl/bcd_byte_alu_chk.sv
// Property checker for bcd_byte_alu, attached by bind; observes ports only.
module bcd_byte_alu_chk
    import bcd_alu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [OP_W-1:0]   op_i,
    input logic              z_i,
    input logic [BYTE_W-1:0] result_o,
    input logic              flag_x_o,
    input logic              flag_n_o,
    input logic              flag_z_o,
    input logic              flag_v_o,
    input logic              flag_c_o,
    input logic              done_o
);
    assert_x_is_c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flag_x_o == flag_c_o));
    assert_n_is_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flag_n_o == result_o[BYTE_W-1]));
    assert_z_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o != '0) |-> !flag_z_o);
    assert_z_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !z_i) |=> !flag_z_o);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(result_o) && $stable(flag_c_o) && $stable(flag_z_o)));
    assert_neg_keeps_v_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == OP_NEG) |=> $stable(flag_v_o));
endmodule

bind bcd_byte_alu bcd_byte_alu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .z_i(z_i),
    .result_o(result_o), .flag_x_o(flag_x_o), .flag_n_o(flag_n_o),
    .flag_z_o(flag_z_o), .flag_v_o(flag_v_o), .flag_c_o(flag_c_o),
    .done_o(done_o)
);

// File: tb/tb_bcd_byte_alu.sv
// Self-checking bench: directed corners, exhaustive negate, seeded random ops.
module tb_bcd_byte_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] op_i = '0;
    logic [7:0] src_i = '0, dst_i = '0;
    logic       x_i = 1'b0, z_i = 1'b0;
    logic [7:0] result_o;
    logic       flag_x_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o, done_o;

    int n_chk = 0, n_bad = 0;
    logic exp_v = 1'b0;
    bit   finished = 1'b0;

    bcd_byte_alu dut (.*);

    always #10 clk = ~clk;

    // Compare one value and report a mismatch.
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference add: returns {res[7:0], c, v}.
    function automatic logic [9:0] ref_add(int s, int d, int x);
        int lo = (s & 15) + (d & 15) + x;
        int raw = (s & 'hF0) + (d & 'hF0) + lo;
        int v = raw; int c;
        if (lo > 9) v += 6;
        c = ((v & 'h3F0) > 'h90) ? 1 : 0;
        if (c != 0) v += 'h60;
        return {8'(v), 1'(c), 1'(((raw & 'h80) == 0) && ((v & 'h80) != 0))};
    endfunction

    function automatic logic [9:0] ref_sub(int s, int d, int x);
        int lo = (d & 15) - (s & 15) - x;
        int raw = (d & 'hF0) - (s & 'hF0) + lo;
        int v = raw; int k = 0; int c;
        if ((lo & 'hF0) != 0) begin v -= 6; k = 6; end
        if (((d - s - x) & 'h100) != 0) v -= 'h60;
        c = (((d - s - k - x) & 'h300) != 0) ? 1 : 0;
        return {8'(v), 1'(c), 1'(((raw & 'h80) != 0) && ((v & 'h80) == 0))};
    endfunction

    function automatic logic [9:0] ref_neg(int s, int x);
        int lo = (0 - (s & 15) - x) & 'hFFFF;
        int v; int c;
        if (lo > 9) lo -= 6;
        v = (0 - (s & 'hF0)) + lo;
        c = ((v & 'h1F0) > 'h90) ? 1 : 0;
        if (c != 0) v -= 'h60;
        return {8'(v), 1'(c), 1'b0};
    endfunction

    // Issue one request and check every output after the registering edge.
    task automatic run_op(input int op, input int s, input int d, input int x, input int z);
        logic [9:0] e;
        string tr, tf;
        @(negedge clk);
        op_i = 2'(op); src_i = 8'(s); dst_i = 8'(d); x_i = 1'(x); z_i = 1'(z);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        case (op)
            1: begin e = ref_sub(s, d, x); tr = "R3 sub result"; tf = "R4 sub C/V"; end
            2: begin e = ref_neg(s, x);    tr = "R5 neg result"; tf = "R5 neg C/V"; end
            3: begin e = ref_add(s, d, x); tr = "R10 op3 result"; tf = "R10 op3 C/V"; end
            default: begin e = ref_add(s, d, x); tr = "R1 add result"; tf = "R2 add C/V"; end
        endcase
        if (op != 2) exp_v = e[0];
        chk(result_o == e[9:2], tr, result_o, e[9:2]);
        chk({flag_c_o, flag_v_o} == {e[1], exp_v}, tf, {flag_c_o, flag_v_o}, {e[1], exp_v});
        chk({flag_x_o, flag_n_o} == {e[1], e[9]}, "R6 X/N", {flag_x_o, flag_n_o}, {e[1], e[9]});
        chk(flag_z_o == (z[0] && e[9:2] == 0), "R7 Z", flag_z_o, (z[0] && e[9:2] == 0));
        chk(done_o == 1'b1, "R8 done", done_o, 1);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog timeout");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (4) @(negedge clk);
        // R9: reset state.
        chk({result_o, flag_x_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o, done_o} == '0,
            "R9 reset", {result_o, flag_x_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o, done_o}, 0);
        rst_n = 1'b1;
        // Directed corners.
        run_op(0, 'h99, 'h99, 1, 1);   // R1 R2 decimal carry out
        run_op(0, 'h00, 'h00, 0, 1);   // R7 zero kept
        run_op(0, 'h01, 'h79, 0, 0);   // R2 overflow set
        run_op(2, 'h00, 'h00, 1, 1);   // R5 negate keeps V, 0x99 borrow
        run_op(2, 'h00, 'h00, 0, 1);   // R5 zero negate
        run_op(1, 'h01, 'h00, 0, 1);   // R3 R4 borrow
        run_op(1, 'hFF, 'hAB, 1, 0);   // R3 non-decimal digits
        run_op(0, 'hFA, 'hCF, 1, 0);   // R1 non-decimal digits
        run_op(3, 'h45, 'h38, 1, 1);   // R10 reserved code
        // R8: hold and done low without a start.
        held = result_o;
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done idle", done_o, 0);
        chk(result_o == held, "R8 hold", result_o, held);
        // R5: exhaustive negate.
        for (int s = 0; s < 256; s++)
            for (int x = 0; x < 2; x++) run_op(2, s, 0, x, 1);
        // Seeded random mix across all codes.
        void'($urandom(32'd1234));
        for (int i = 0; i < 20000; i++)
            run_op($urandom % 4, $urandom % 256, $urandom % 256, $urandom % 2, $urandom % 2);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule